// File: doc/BRIEF.md
# Buffered Burst JTAG Master

This block drives a JTAG port in whole bursts instead of toggling the pins one write at a time. A host fills two 128-bit buffers through a small word-addressed register interface. One buffer holds the mode-select bit for each clock and the other holds the serial data to send. The host then sets a clock divider and a burst length and writes a start command. The block issues the requested number of test clocks. It sends one bit of each buffer per clock and stores the returning serial bit of each clock in a 128-bit capture buffer. When it is done it raises an interrupt.

Between bursts the test clock is held low for as long as the host likes, and no timing relation between bursts is assumed. The host's loop is to fill the buffers, start the burst, wait for the interrupt, read the capture words, and clear the interrupt. The divider lets the test clock be set, for example, anywhere from 100 kHz to 1 MHz from a faster system clock.

Top module: `jtag_burst_master`

## Requirements
- R1: After reset, every readable register reads 0, jtagClk, jtagMode and jtagDataOut are 0, and irq is 0.
- R2: Register map, by word address: 0-3 hold the mode buffer and 4-7 the send buffer (read/write, address 0 and 4 carry bits 0-31). Addresses 8-11 are the capture buffer (read only). Address 12 is the divider (16 bits) and address 13 the length (8 bits). Writing address 14 with bit 0 set starts a burst. Address 15 is status: bit 0 is busy and bit 1 is the interrupt flag.
- R3: A start issues exactly L rising edges of jtagClk, where L is the length register value and a value of 0 gives 128 edges.
- R4: Each high phase and each low phase of jtagClk lasts divider+1 system clock cycles. The divider and length values are taken at start, so later writes do not affect a running burst.
- R5: Bits go out least significant first, starting at bit 0 of word 0 and continuing into word 3. jtagMode and jtagDataOut change only while jtagClk is low and hold steady through each high phase. jtagClk is low whenever no burst runs.
- R6: jtagDataIn is sampled on each rising edge of jtagClk and stored in the capture buffer at the index of the bit sent on that clock. Capture bits at or beyond L keep their previous values.
- R7: The busy bit reads 1 from the start command until the last falling edge of jtagClk. A start written while busy is ignored.
- R8: irq and the status interrupt flag are set when a burst completes. They stay set until status is written with bit 1 set. Writing 0 to bit 1 leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| jtagClk | output | 1 | Test clock |
| jtagMode | output | 1 | Mode-select line |
| jtagDataOut | output | 1 | Serial data to the device |
| jtagDataIn | input | 1 | Serial data from the device |
| irq | output | 1 | Burst-complete interrupt |

## Verification
A wrong bit index or buffer slice shows up on the very first burst. The bits seen on jtagMode and jtagDataOut at each rising test clock stop matching the loaded words, and the capture words read back wrong. The bench loops the output back as jtagDataIn = jtagDataOut XOR jtagMode, so a swap of the two lines or of two words is also caught. A fault in the divider or phase state appears within two test-clock periods as a wrong edge spacing, or as a wrong edge count when the burst ends. A fault in the busy or interrupt state is seen at the end of the burst in the status read and on irq.

// File: rtl/jbm_pkg.sv
`timescale 1ns/1ps
package jbm_pkg;
  // strobes from the sequencing control to the buffer datapath
  typedef struct packed {
    logic start;  // burst accepted this cycle
    logic rise;   // test clock goes high at this edge
    logic fall;   // test clock goes low at this edge
    logic done;   // this fall ends the burst
  } jbmStrobe_t;
endpackage

// File: rtl/jbm_ctrl.sv
`timescale 1ns/1ps
module jbm_ctrl
  import jbm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goReq,
  input  logic [DIV_W-1:0] divVal,
  input  logic             lastBit,
  output logic             tck,
  output logic             busy,
  output jbmStrobe_t       strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} phase_e;

  phase_e          state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divQ;
  logic             tckQ;
  logic             halfDone;

  assign halfDone = (cnt == divQ);
  assign busy     = (state != ST_IDLE);
  assign tck      = tckQ;

  always_comb begin
    strobe       = '0;
    strobe.start = goReq && (state == ST_IDLE);
    strobe.rise  = (state == ST_LOW) && halfDone;
    strobe.fall  = (state == ST_HIGH) && halfDone;
    strobe.done  = strobe.fall && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      divQ  <= '0;
      tckQ  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe.start) begin
            divQ  <= divVal;
            cnt   <= '0;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (halfDone) begin
            cnt   <= '0;
            tckQ  <= 1'b1;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            cnt   <= '0;
            tckQ  <= 1'b0;
            state <= lastBit ? ST_IDLE : ST_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: clock stays low outside a burst
  p_tck_idle_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !tckQ);

  // R4: a clock transition happens only after a full phase count
  p_half_period_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && (tckQ != $past(tckQ))) |-> ($past(cnt) == $past(divQ)));

  // R7: a start during a burst does not end or restart it
  p_go_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && goReq && !strobe.done) |=> (busy && $stable(divQ)));
endmodule

// File: rtl/jbm_datapath.sv
`timescale 1ns/1ps
module jbm_datapath
  import jbm_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16,
  localparam int BITS   = WORDS * WORD_W,
  localparam int IDX_W  = $clog2(BITS),
  localparam int LEN_W  = IDX_W + 1,
  localparam int ADDR_W = $clog2(3 * WORDS + 4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  jbmStrobe_t        strobe,
  input  logic              busy,
  input  logic              tck,
  input  logic              serIn,
  output logic              goReq,
  output logic [DIV_W-1:0]  divVal,
  output logic              lastBit,
  output logic              modeOut,
  output logic              serOut,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] MODE_A = '0;
  localparam logic [ADDR_W-1:0] SEND_A = ADDR_W'(WORDS);
  localparam logic [ADDR_W-1:0] CAPT_A = ADDR_W'(2 * WORDS);
  localparam logic [ADDR_W-1:0] DIV_A  = ADDR_W'(3 * WORDS);
  localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(3 * WORDS + 1);
  localparam logic [ADDR_W-1:0] GO_A   = ADDR_W'(3 * WORDS + 2);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(3 * WORDS + 3);

  logic [BITS-1:0]  modeBits, sendBits, captBits;
  logic [DIV_W-1:0] divReg;
  logic [LEN_W-1:0] lenReg;
  logic [IDX_W-1:0] bitIdx, lastIdx, lenLast, nextIdx;
  logic             modeQ, serQ, irqQ, irqClr;

  assign lenLast = lenReg[IDX_W-1:0] - IDX_W'(1);  // 0 wraps to full length
  assign nextIdx = bitIdx + IDX_W'(1);
  assign lastBit = (bitIdx == lastIdx);
  assign goReq   = regWrEn && (regAddr == GO_A) && regWrData[0];
  assign irqClr  = regWrEn && (regAddr == STAT_A) && regWrData[1];
  assign divVal  = divReg;
  assign modeOut = modeQ;
  assign serOut  = serQ;
  assign irqOut  = irqQ;

  // host-side register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBits <= '0;
      sendBits <= '0;
      divReg   <= '0;
      lenReg   <= '0;
    end else if (regWrEn) begin
      for (int k = 0; k < WORDS; k++) begin
        if (regAddr == MODE_A + ADDR_W'(k)) modeBits[k*WORD_W +: WORD_W] <= regWrData;
        if (regAddr == SEND_A + ADDR_W'(k)) sendBits[k*WORD_W +: WORD_W] <= regWrData;
      end
      if (regAddr == DIV_A) divReg <= regWrData[DIV_W-1:0];
      if (regAddr == LEN_A) lenReg <= regWrData[LEN_W-1:0];
    end
  end

  // shift engine: pins, bit index, capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= '0;
      lastIdx  <= '0;
      modeQ    <= 1'b0;
      serQ     <= 1'b0;
      captBits <= '0;
    end else begin
      if (strobe.start) begin
        bitIdx  <= '0;
        lastIdx <= lenLast;
        modeQ   <= modeBits[0];
        serQ    <= sendBits[0];
      end
      if (strobe.rise) captBits[bitIdx] <= serIn;
      if (strobe.fall && !strobe.done) begin
        bitIdx <= nextIdx;
        modeQ  <= modeBits[nextIdx];
        serQ   <= sendBits[nextIdx];
      end
    end
  end

  // completion flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)            irqQ <= 1'b0;
    else if (strobe.done) irqQ <= 1'b1;
    else if (irqClr)      irqQ <= 1'b0;
  end

  always_comb begin
    regRdData = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (regAddr == MODE_A + ADDR_W'(k)) regRdData = modeBits[k*WORD_W +: WORD_W];
      if (regAddr == SEND_A + ADDR_W'(k)) regRdData = sendBits[k*WORD_W +: WORD_W];
      if (regAddr == CAPT_A + ADDR_W'(k)) regRdData = captBits[k*WORD_W +: WORD_W];
    end
    if (regAddr == DIV_A)  regRdData = WORD_W'(divReg);
    if (regAddr == LEN_A)  regRdData = WORD_W'(lenReg);
    if (regAddr == STAT_A) regRdData = WORD_W'({irqQ, busy});
  end

  // R5: lines hold steady while the test clock is high
  p_pins_hold_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(modeQ) && $stable(serQ)));

  // R3: the index never runs past the latched length
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= lastIdx));

  // R8: the flag only rises at burst completion
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(strobe.done));

  // R8: the flag holds until an explicit clear
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !irqClr) |=> irqQ);
endmodule

// File: rtl/jtag_burst_master.sv
`timescale 1ns/1ps
module jtag_burst_master
  import jbm_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16,
  localparam int ADDR_W = $clog2(3 * WORDS + 4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              jtagClk,
  output logic              jtagMode,
  output logic              jtagDataOut,
  input  logic              jtagDataIn,
  output logic              irq
);
  jbmStrobe_t       strobe;
  logic             goReq, lastBit, busy;
  logic [DIV_W-1:0] divVal;

  jbm_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .goReq   (goReq),
    .divVal  (divVal),
    .lastBit (lastBit),
    .tck     (jtagClk),
    .busy    (busy),
    .strobe  (strobe)
  );

  jbm_datapath #(.WORDS(WORDS), .WORD_W(WORD_W), .DIV_W(DIV_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .busy      (busy),
    .tck       (jtagClk),
    .serIn     (jtagDataIn),
    .goReq     (goReq),
    .divVal    (divVal),
    .lastBit   (lastBit),
    .modeOut   (jtagMode),
    .serOut    (jtagDataOut),
    .irqOut    (irq)
  );
endmodule

// File: tb/sim_jtag_burst_master.sv
`timescale 1ns/1ps
module sim_jtag_burst_master;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        jtagClk, jtagMode, jtagDataOut, jtagDataIn, irq;

  always #2 clk = ~clk;  // 250 MHz

  jtag_burst_master u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .jtagClk(jtagClk),
    .jtagMode(jtagMode), .jtagDataOut(jtagDataOut), .jtagDataIn(jtagDataIn), .irq(irq)
  );

  // device model: returns data XOR mode so line swaps are visible
  assign jtagDataIn = jtagDataOut ^ jtagMode;

  int checks = 0;
  int errors = 0;

  // rising-edge monitor
  localparam int LOG_N = 2048;
  int  riseCnt = 0;
  logic seenMode [LOG_N];
  logic seenData [LOG_N];
  time  riseT    [LOG_N];
  always @(posedge jtagClk) begin
    if (riseCnt < LOG_N) begin
      seenMode[riseCnt] = jtagMode;
      seenData[riseCnt] = jtagDataOut;
      riseT[riseCnt]    = $time;
    end
    riseCnt = riseCnt + 1;
  end

  logic [127:0] captModel = '0;

  // div[39:24], len[23:16], seed[15:0]
  localparam logic [39:0] VEC [7] = '{
    {16'd0, 8'd1,   16'h1357},
    {16'd0, 8'd128, 16'hA5C3},
    {16'd1, 8'd37,  16'h0F0F},
    {16'd3, 8'd0,   16'h7E11},
    {16'd2, 8'd64,  16'h2468},
    {16'd0, 8'd33,  16'hBEEF},
    {16'd5, 8'd2,   16'h4242}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] genWord(input logic [15:0] seed, input int k);
    return ({seed, seed} * 32'h9E3779B1) ^ (32'(k + 1) * 32'h2545F491);
  endfunction

  task automatic waitIrq();
    for (int n = 0; n < 40000 && !irq; n++) @(negedge clk);
  endtask

  task automatic runBurst(input logic [15:0] dv, input logic [7:0] ln, input logic [15:0] seed);
    logic [127:0] mBits, sBits, gotM, gotS, mask;
    logic [31:0]  r;
    int effLen, base;
    for (int k = 0; k < 4; k++) begin
      mBits[k*32 +: 32] = genWord(seed, k);
      sBits[k*32 +: 32] = genWord(~seed, k + 7);
      wr(4'(k), mBits[k*32 +: 32]);
      wr(4'(k + 4), sBits[k*32 +: 32]);
    end
    wr(4'd12, 32'(dv));
    wr(4'd13, 32'(ln));
    effLen = (ln == 0) ? 128 : int'(ln);
    base = riseCnt;
    wr(4'd14, 32'h1);
    rd(4'd15, r);
    chk("R7 busy after start", r & 32'h1, 32'h1);
    waitIrq();
    chk("R3 rising edge count", 32'(riseCnt - base), 32'(effLen));
    mask = '0; gotM = '0; gotS = '0;
    for (int i = 0; i < effLen; i++) begin
      mask[i] = 1'b1;
      if (base + i < LOG_N) begin
        gotM[i] = seenMode[base + i];
        gotS[i] = seenData[base + i];
      end
      captModel[i] = sBits[i] ^ mBits[i];
    end
    for (int k = 0; k < 4; k++) begin
      chk("R5 mode bit order", gotM[k*32 +: 32], mBits[k*32 +: 32] & mask[k*32 +: 32]);
      chk("R5 data bit order", gotS[k*32 +: 32], sBits[k*32 +: 32] & mask[k*32 +: 32]);
      rd(4'(k + 8), r);
      chk("R6 capture word", r, captModel[k*32 +: 32]);
    end
    if (effLen >= 2 && base + 1 < LOG_N)
      chk("R4 clock period", 32'(riseT[base + 1] - riseT[base]), 32'(8 * (int'(dv) + 1)));
    chk("R5 clock idle low", 32'(jtagClk), 32'h0);
    rd(4'd15, r);
    chk("R7 busy clear, R8 flag set", r, 32'h2);
    chk("R8 irq pin set", 32'(irq), 32'h1);
    wr(4'd15, 32'h1);
    chk("R8 write of zero keeps irq", 32'(irq), 32'h1);
    wr(4'd15, 32'h2);
    chk("R8 clear by write one", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=expired expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      chk("R1 register reset", r, 32'h0);
    end
    chk("R1 pins reset", {29'b0, jtagClk, jtagMode, jtagDataOut}, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 readback of divider and length
    wr(4'd12, 32'hFFFF_1234);
    rd(4'd12, r);
    chk("R2 divider readback", r, 32'h1234);
    wr(4'd13, 32'hFFFF_FF81);
    rd(4'd13, r);
    chk("R2 length readback", r, 32'h81);

    for (int v = 0; v < 7; v++)
      runBurst(VEC[v][39:24], VEC[v][23:16], VEC[v][15:0]);

    // R7: start while busy ignored; R4: length change mid-burst has no effect
    wr(4'd12, 32'd3);
    wr(4'd13, 32'd8);
    base = riseCnt;
    wr(4'd14, 32'h1);
    repeat (10) @(negedge clk);
    wr(4'd13, 32'd20);
    wr(4'd14, 32'h1);
    waitIrq();
    chk("R7 second start ignored", 32'(riseCnt - base), 32'd8);
    wr(4'd15, 32'h2);
    repeat (60) @(negedge clk);
    chk("R7 no late burst", 32'(riseCnt - base), 32'd8);
    rd(4'd15, r);
    chk("R7 idle status", r, 32'h0);

    // R2: start command needs bit 0
    base = riseCnt;
    wr(4'd14, 32'h2);
    repeat (20) @(negedge clk);
    chk("R2 start needs bit 0", 32'(riseCnt - base), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule